// File: doc/BRIEF.md
# Destination Address Filter

This block decides whether a received frame is kept or dropped, based only on its 48-bit destination address. Four programmable exact-match slots, a 64-entry hash table for group addresses, a broadcast switch and a promiscuous switch each give a way for a frame to be accepted. The decision comes out one clock after the address is presented. It carries a code that names which rule produced the match.

Software programs each slot and the hash table through a plain register write port. Each one is a pair of registers: a low register and then a high register. A pair takes no part in matching from the moment its low register is written until its high register is written. A frame that arrives while software is partway through an update is therefore never compared against an address that is half old and half new. Register writes are allowed at any time, whether or not frames are flowing.

The address is taken with bit 0 as bit 0 of the first byte on the wire. That bit is the group (multicast) bit.

Top module: `dest_addr_filter`

## Requirements
- R1: For every cycle in which `da_valid` is high, `dec_valid` is high in the next cycle and in no other cycle. While `dec_valid` is low, `dec_accept` and `dec_reason` are 0.
- R2: After synchronous reset, all four slots and the hash table take no part in matching, the hash table bits are 0, and `dec_valid` is 0. A non-broadcast frame with promiscuous mode off is rejected with reason 0.
- R3: A non-broadcast address equal to an enabled slot is accepted. The reason is 1, 2, 3 or 4 for slot 0, 1, 2 or 3, and the lowest-numbered matching slot is reported. A rejected frame has reason 0.
- R4: Slot n has its low register at write address 2n, which holds address bits 31:0. Its high register is at address 2n+1 and holds bits 47:32 from write data bits 15:0. Writing the low register disables the slot. Writing the high register enables it with the new 48-bit value.
- R5: A non-broadcast address with bit 0 set is accepted with reason 5 when the hash table is enabled and the selected table bit is 1. The 6-bit index has bit k equal to the XOR of address bits k, k+6, k+12, ... up to bit 47. Table indices 0–31 are bits 31:0 of the hash low register, and indices 32–63 are bits 31:0 of the hash high register. Addresses with bit 0 clear never match the hash table.
- R6: The hash low register is at write address 8 and the hash high register is at address 9. Writing address 8 disables hash matching, and writing address 9 enables it.
- R7: The all-ones address is accepted with reason 6 only when `cfg_bcast_en` is 1. It is never matched through a slot or the hash table.
- R8: When `cfg_promisc` is 1, every frame is accepted. The reason is 7 only if no slot, hash or broadcast rule matched. Otherwise it is that rule's code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_bcast_en | input | 1 | Accept the all-ones address |
| cfg_promisc | input | 1 | Accept every frame |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 4 | Register write address (0–9 used) |
| reg_wr_data | input | 32 | Register write data |
| da_valid | input | 1 | Destination address valid strobe |
| da | input | 48 | Destination address, bit 0 is the group bit |
| dec_valid | output | 1 | Decision valid, one cycle after `da_valid` |
| dec_accept | output | 1 | Frame accepted |
| dec_reason | output | 3 | Match code: 0 none, 1–4 slot, 5 hash, 6 broadcast, 7 promiscuous |

## Verification
The bench sends frames while a slot is in the middle of an update. In that window it expects both the old and the new address to be rejected, which would fail on a design that compares against the half-written value. It programs hash bits in both halves of the table and sends a unicast address with the same index as a set bit. This catches swapped halves, a wrong index fold, and a missing group-bit test. It also loads two slots with the same address to check lowest-slot priority. It sends broadcast frames with the broadcast switch off and a fully set hash table, which a design that lets broadcast fall through to the hash would accept.

// File: rtl/daf_pkg.sv
package daf_pkg;
    localparam int ADDR_W    = 48;
    localparam int LO_W      = 32;
    localparam int HI_W      = ADDR_W - LO_W;
    localparam int NUM_SLOTS = 4;
    localparam int HASH_BITS = 6;
    localparam int HASH_SIZE = 1 << HASH_BITS;
    localparam int REG_AW    = 4;
    localparam int RSN_W     = 3;
    localparam int FOLD      = ADDR_W / HASH_BITS;

    localparam logic [REG_AW-1:0] REG_HASH_LO = REG_AW'(2 * NUM_SLOTS);
    localparam logic [REG_AW-1:0] REG_HASH_HI = REG_AW'(2 * NUM_SLOTS + 1);

    typedef enum logic [RSN_W-1:0] {
        RSN_NONE    = 3'd0,
        RSN_SLOT0   = 3'd1,
        RSN_SLOT1   = 3'd2,
        RSN_SLOT2   = 3'd3,
        RSN_SLOT3   = 3'd4,
        RSN_HASH    = 3'd5,
        RSN_BCAST   = 3'd6,
        RSN_PROMISC = 3'd7
    } reason_e;

    typedef struct packed {
        logic    accept;
        reason_e reason;
    } verdict_t;

    // Fold the address into a table index: bit k collects every sixth bit from k.
    function automatic logic [HASH_BITS-1:0] hash_index(input logic [ADDR_W-1:0] a);
        logic [HASH_BITS-1:0] idx;
        idx = '0;
        for (int j = 0; j < FOLD; j++) begin
            idx = idx ^ a[j*HASH_BITS +: HASH_BITS];
        end
        return idx;
    endfunction
endpackage

// File: rtl/daf_slot_bank.sv
module daf_slot_bank
    import daf_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [REG_AW-1:0]     wr_addr,
    input  logic [LO_W-1:0]       wr_data,
    input  logic [ADDR_W-1:0]     da,
    output logic [NUM_SLOTS-1:0]  slot_vld,
    output logic [NUM_SLOTS-1:0]  slot_hit
);
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        localparam logic [REG_AW-1:0] A_LO = REG_AW'(2 * g);
        localparam logic [REG_AW-1:0] A_HI = REG_AW'(2 * g + 1);

        logic [LO_W-1:0] lo_q;
        logic [HI_W-1:0] hi_q;
        logic            vld_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                lo_q  <= '0;
                hi_q  <= '0;
                vld_q <= 1'b0;
            end else if (wr_en) begin
                if (wr_addr == A_LO) begin
                    lo_q  <= wr_data;
                    vld_q <= 1'b0;
                end else if (wr_addr == A_HI) begin
                    hi_q  <= wr_data[HI_W-1:0];
                    vld_q <= 1'b1;
                end
            end
        end

        assign slot_vld[g] = vld_q;
        assign slot_hit[g] = vld_q && (da == {hi_q, lo_q});
    end
endmodule

// File: rtl/daf_hash_table.sv
module daf_hash_table
    import daf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [LO_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0] da,
    output logic              hash_hit
);
    localparam int HALF = HASH_SIZE / 2;

    logic [HALF-1:0]      tbl_lo_q;
    logic [HALF-1:0]      tbl_hi_q;
    logic                 tbl_vld_q;
    logic [HASH_BITS-1:0] idx;
    logic [HASH_SIZE-1:0] tbl;

    always_ff @(posedge clk) begin
        if (rst) begin
            tbl_lo_q  <= '0;
            tbl_hi_q  <= '0;
            tbl_vld_q <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == REG_HASH_LO) begin
                tbl_lo_q  <= wr_data[HALF-1:0];
                tbl_vld_q <= 1'b0;
            end else if (wr_addr == REG_HASH_HI) begin
                tbl_hi_q  <= wr_data[HALF-1:0];
                tbl_vld_q <= 1'b1;
            end
        end
    end

    always_comb begin
        idx      = hash_index(da);
        tbl      = {tbl_hi_q, tbl_lo_q};
        hash_hit = tbl_vld_q && da[0] && tbl[idx];
    end
endmodule

// File: rtl/daf_decide.sv
module daf_decide
    import daf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 da_valid,
    input  logic [ADDR_W-1:0]    da,
    input  logic [NUM_SLOTS-1:0] slot_hit,
    input  logic                 hash_hit,
    input  logic                 cfg_bcast_en,
    input  logic                 cfg_promisc,
    output logic                 dec_valid,
    output verdict_t             dec_verdict
);
    verdict_t nxt;
    logic     is_bcast;

    always_comb begin
        is_bcast    = &da;
        nxt.accept  = 1'b0;
        nxt.reason  = RSN_NONE;
        if (is_bcast) begin
            if (cfg_bcast_en) nxt.reason = RSN_BCAST;
        end else if (|slot_hit) begin
            for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
                if (slot_hit[i]) nxt.reason = reason_e'(RSN_W'(i + 1));
            end
        end else if (hash_hit) begin
            nxt.reason = RSN_HASH;
        end
        if (nxt.reason == RSN_NONE && cfg_promisc) nxt.reason = RSN_PROMISC;
        nxt.accept = (nxt.reason != RSN_NONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_valid   <= 1'b0;
            dec_verdict <= '0;
        end else begin
            dec_valid   <= da_valid;
            dec_verdict <= da_valid ? nxt : '0;
        end
    end
endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter
    import daf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_bcast_en,
    input  logic              cfg_promisc,
    input  logic              reg_wr_en,
    input  logic [REG_AW-1:0] reg_wr_addr,
    input  logic [LO_W-1:0]   reg_wr_data,
    input  logic              da_valid,
    input  logic [ADDR_W-1:0] da,
    output logic              dec_valid,
    output logic              dec_accept,
    output logic [RSN_W-1:0]  dec_reason
);
    logic [NUM_SLOTS-1:0] slot_vld;
    logic [NUM_SLOTS-1:0] slot_hit;
    logic                 hash_hit;
    verdict_t             verdict;

    daf_slot_bank u_slots (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_wr_en),
        .wr_addr  (reg_wr_addr),
        .wr_data  (reg_wr_data),
        .da       (da),
        .slot_vld (slot_vld),
        .slot_hit (slot_hit)
    );

    daf_hash_table u_hash (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_wr_en),
        .wr_addr  (reg_wr_addr),
        .wr_data  (reg_wr_data),
        .da       (da),
        .hash_hit (hash_hit)
    );

    daf_decide u_decide (
        .clk          (clk),
        .rst          (rst),
        .da_valid     (da_valid),
        .da           (da),
        .slot_hit     (slot_hit),
        .hash_hit     (hash_hit),
        .cfg_bcast_en (cfg_bcast_en),
        .cfg_promisc  (cfg_promisc),
        .dec_valid    (dec_valid),
        .dec_verdict  (verdict)
    );

    assign dec_accept = verdict.accept;
    assign dec_reason = verdict.reason;
endmodule

// File: rtl/dest_addr_filter_chk.sv
module dest_addr_filter_chk
    import daf_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 cfg_bcast_en,
    input logic                 cfg_promisc,
    input logic                 reg_wr_en,
    input logic [REG_AW-1:0]    reg_wr_addr,
    input logic                 da_valid,
    input logic [ADDR_W-1:0]    da,
    input logic                 dec_valid,
    input logic                 dec_accept,
    input logic [RSN_W-1:0]     dec_reason,
    input logic [NUM_SLOTS-1:0] slot_vld
);
    assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
        da_valid |=> dec_valid);

    assert_no_spurious_R1: assert property (@(posedge clk) disable iff (rst)
        !da_valid |=> !dec_valid);

    assert_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !dec_valid |-> (!dec_accept && dec_reason == '0));

    assert_reset_state_R2: assert property (@(posedge clk)
        rst |=> (slot_vld == '0 && !dec_valid));

    assert_reason_code_R3: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> (dec_accept == (dec_reason != '0)));

    assert_low_disables_R4: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && reg_wr_addr < REG_HASH_LO && !reg_wr_addr[0])
        |=> !slot_vld[$past(reg_wr_addr[2:1])]);

    assert_high_enables_R4: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && reg_wr_addr < REG_HASH_LO && reg_wr_addr[0])
        |=> slot_vld[$past(reg_wr_addr[2:1])]);

    assert_bcast_blocked_R7: assert property (@(posedge clk) disable iff (rst)
        (da_valid && (&da) && !cfg_bcast_en && !cfg_promisc) |=> !dec_accept);

    assert_promisc_accepts_R8: assert property (@(posedge clk) disable iff (rst)
        (da_valid && cfg_promisc) |=> dec_accept);
endmodule

bind dest_addr_filter dest_addr_filter_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_bcast_en (cfg_bcast_en),
    .cfg_promisc  (cfg_promisc),
    .reg_wr_en    (reg_wr_en),
    .reg_wr_addr  (reg_wr_addr),
    .da_valid     (da_valid),
    .da           (da),
    .dec_valid    (dec_valid),
    .dec_accept   (dec_accept),
    .dec_reason   (dec_reason),
    .slot_vld     (slot_vld)
);

// File: tb/dest_addr_filter_test.sv
module dest_addr_filter_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_bcast_en = 1'b0;
    logic        cfg_promisc = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [3:0]  reg_wr_addr = '0;
    logic [31:0] reg_wr_data = '0;
    logic        da_valid = 1'b0;
    logic [47:0] da = '0;
    logic        dec_valid;
    logic        dec_accept;
    logic [2:0]  dec_reason;

    always #5 clk = ~clk;

    dest_addr_filter uut (
        .clk          (clk),
        .rst          (rst),
        .cfg_bcast_en (cfg_bcast_en),
        .cfg_promisc  (cfg_promisc),
        .reg_wr_en    (reg_wr_en),
        .reg_wr_addr  (reg_wr_addr),
        .reg_wr_data  (reg_wr_data),
        .da_valid     (da_valid),
        .da           (da),
        .dec_valid    (dec_valid),
        .dec_accept   (dec_accept),
        .dec_reason   (dec_reason)
    );

    typedef struct {
        logic       acc;
        logic [2:0] rsn;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fail   = 0;

    // Shadow of the programmed state, kept by the rules of R4 and R6.
    logic [31:0] sh_lo [4];
    logic [15:0] sh_hi [4];
    logic        sh_ok [4];
    logic [31:0] sh_hlo, sh_hhi;
    logic        sh_hok;

    function automatic logic [5:0] ref_index(input logic [47:0] a);
        logic [5:0] r = '0;
        for (int b = 0; b < 48; b++) r[b % 6] = r[b % 6] ^ a[b];
        return r;
    endfunction

    function automatic exp_t predict(input logic [47:0] a, input string tag);
        exp_t e;
        logic [63:0] t;
        e.rsn = 3'd0;
        e.tag = tag;
        if (a == 48'hFFFF_FFFF_FFFF) begin
            if (cfg_bcast_en) e.rsn = 3'd6;
        end else begin
            for (int i = 3; i >= 0; i--)
                if (sh_ok[i] && a == {sh_hi[i], sh_lo[i]}) e.rsn = 3'(i + 1);
            t = {sh_hhi, sh_hlo};
            if (e.rsn == 3'd0 && sh_hok && a[0] && t[ref_index(a)]) e.rsn = 3'd5;
        end
        if (e.rsn == 3'd0 && cfg_promisc) e.rsn = 3'd7;
        e.acc = (e.rsn != 3'd0);
        return e;
    endfunction

    task automatic check(input logic ok, input string tag, input string what,
                         input logic [47:0] act, input logic [47:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
        @(posedge clk); #1;
        reg_wr_en = 1'b0;
        if (a < 4'd8) begin
            if (!a[0]) begin sh_lo[a[2:1]] = d; sh_ok[a[2:1]] = 1'b0; end
            else begin sh_hi[a[2:1]] = d[15:0]; sh_ok[a[2:1]] = 1'b1; end
        end else if (a == 4'd8) begin
            sh_hlo = d; sh_hok = 1'b0;
        end else if (a == 4'd9) begin
            sh_hhi = d; sh_hok = 1'b1;
        end
    endtask

    task automatic program_slot(input int s, input logic [47:0] a);
        reg_write(4'(2 * s), a[31:0]);
        reg_write(4'(2 * s + 1), {16'h0, a[47:32]});
    endtask

    // Driver: present one address, queue its expected verdict, and check R1 latency.
    task automatic send(input logic [47:0] a, input string tag);
        @(posedge clk); #1;
        da = a; da_valid = 1'b1;
        q.push_back(predict(a, tag));
        @(posedge clk); #2;
        check(dec_valid === 1'b1, "R1", "dec_valid one cycle after strobe",
              48'(dec_valid), 48'h1);
        da_valid = 1'b0;
    endtask

    // Monitor: pop and compare each decision.
    always @(negedge clk) begin
        if (!rst && dec_valid) begin
            if (q.size() == 0) begin
                check(1'b0, "R1", "decision without strobe", 48'h1, 48'h0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(dec_accept === e.acc && dec_reason === e.rsn, e.tag, "verdict",
                      {44'h0, dec_accept, dec_reason}, {44'h0, e.acc, e.rsn});
            end
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", "run timed out", 48'h0, 48'h1);
        finish_run();
    end

    initial begin
        logic [47:0] hA, hD, hE, uC;
        logic [63:0] t;
        for (int i = 0; i < 4; i++) begin sh_lo[i] = '0; sh_hi[i] = '0; sh_ok[i] = 1'b0; end
        sh_hlo = '0; sh_hhi = '0; sh_hok = 1'b0;

        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R2: outputs quiet after reset
        check(dec_valid === 1'b0 && dec_accept === 1'b0 && dec_reason === 3'd0, "R2",
              "reset outputs", {45'h0, dec_valid, dec_accept, dec_reason[0]}, 48'h0);
        // R2: nothing matches; zero address would equal an unprogrammed slot
        send(48'h0000_0000_0000, "R2");
        send(48'h0011_2233_4455, "R2");
        send(48'h0000_5E00_0001, "R2");

        // R3: each slot reports its own code
        program_slot(0, 48'h0A0B_0C0D_0E10);
        program_slot(1, 48'h1234_5678_9AB2);
        program_slot(2, 48'h00C0_FFEE_0004);
        program_slot(3, 48'hDEAD_BEEF_0006);
        send(48'h0A0B_0C0D_0E10, "R3");
        send(48'h1234_5678_9AB2, "R3");
        send(48'h00C0_FFEE_0004, "R3");
        send(48'hDEAD_BEEF_0006, "R3");
        send(48'hDEAD_BEEF_0008, "R3");
        // R3: duplicate address, lowest slot wins
        program_slot(3, 48'h1234_5678_9AB2);
        send(48'h1234_5678_9AB2, "R3");

        // R4: low write disables slot 0; neither old nor new address matches
        reg_write(4'd0, 32'h7777_8888);
        send(48'h0A0B_0C0D_0E10, "R4");
        send(48'h0A0B_7777_8888, "R4");
        send(48'h5555_7777_8888, "R4");
        reg_write(4'd1, 32'hFFFF_5555);
        send(48'h5555_7777_8888, "R4");
        send(48'h0A0B_0C0D_0E10, "R4");

        // R5: hash entries in both halves of the table
        hA = 48'h0000_5E00_0001;
        hD = hA ^ 48'h20;
        hE = hA ^ 48'h02;
        uC = hA ^ 48'h41;
        t  = (64'h1 << ref_index(hA)) | (64'h1 << ref_index(hD));
        reg_write(4'd8, t[31:0]);
        reg_write(4'd9, t[63:32]);
        send(hA, "R5");
        send(hD, "R5");
        send(hE, "R5");
        send(uC, "R5");

        // R6: hash low write disables hash matching until the high write
        reg_write(4'd8, t[31:0]);
        send(hA, "R6");
        send(hD, "R6");
        reg_write(4'd9, t[63:32]);
        send(hA, "R6");

        // R7: broadcast blocked even with a full hash table and matching slot
        reg_write(4'd8, 32'hFFFF_FFFF);
        reg_write(4'd9, 32'hFFFF_FFFF);
        program_slot(2, 48'hFFFF_FFFF_FFFF);
        send(48'hFFFF_FFFF_FFFF, "R7");
        @(posedge clk); #1 cfg_bcast_en = 1'b1;
        send(48'hFFFF_FFFF_FFFF, "R7");
        send(48'h0100_0000_0003, "R7");
        @(posedge clk); #1 cfg_bcast_en = 1'b0;

        // R8: promiscuous accepts everything, specific reasons still win
        @(posedge clk); #1 cfg_promisc = 1'b1;
        send(48'h0000_0000_0042, "R8");
        send(48'hFFFF_FFFF_FFFF, "R8");
        send(48'h1234_5678_9AB2, "R8");
        send(48'h0000_0000_0043, "R8");
        @(posedge clk); #1 cfg_promisc = 1'b0;
        send(48'h0000_0000_0042, "R8");

        repeat (4) @(posedge clk);
        @(negedge clk);
        check(q.size() == 0, "R1", "every strobe got one decision",
              48'(q.size()), 48'h0);
        finish_run();
    end
endmodule